// File: doc/BRIEF.md
# Folded Eight-Tap Constant-Coefficient FIR Filter

This block is a linear-phase FIR filter that accepts one signed sample on every clock. Its coefficients are constants fixed at elaboration. The filter exploits coefficient symmetry. The eight taps of a section are folded into four mirrored pairs, and each pair is combined before any multiplication, so only four products remain per section. Those four products are formed without hardware multipliers. Each bit-plane of the four folded words addresses a 16-entry table that holds every subset sum of the four coefficients. The bit-plane results are shifted and accumulated, and the sign plane is subtracted.

The folding adders can be elaborated as subtractors, which gives a filter with an odd impulse response. An optional register stage between the folding logic and the table accumulation shortens the critical path at the cost of one clock of latency. Longer filters are built by setting the section count. Sections share one continuous delay line, so each section receives the samples that have passed through the section before it, and the outputs of all sections are summed. An asynchronous clear empties the whole datapath.

Top module: `sym_da_fir`

## Requirements
- R1: Samples on `x_in` and results on `y_out` are two's complement. With the register stage enabled (`PIPE`=1), the value sampled at clock edge n first appears as the newest tap in the `y_out` produced by edge n+2. That output is the sum over pairs k of COEFS[k]·(tap[k] ± tap[7−k]), where tap 0 is the newest sample of the section, kept to the low `OW` bits.
- R2: In add mode (`FOLD`=FOLD_ADD), the pair members are added. A single unit sample followed by zeros gives the response h0,h1,h2,h3,h3,h2,h1,h0, where hi = COEFS[i] and index 0 is the outermost pair.
- R3: In subtract mode (`FOLD`=FOLD_SUB), the older member of each pair is subtracted from the newer member. A unit impulse gives h0,h1,h2,h3,−h3,−h2,−h1,−h0.
- R4: Without the register stage (`PIPE`=0), the latency is two clocks instead of three: the sample taken at edge n is the newest tap in the output of edge n+1. The output values are otherwise the same as in R1.
- R5: Raising `clr` zeroes the delay line, the folded-word registers and `y_out` at once, without waiting for a clock. `y_out` stays zero while `clr` is high and for the first edges after release until a new sample can reach the output. No sample taken before the clear affects any later output.
- R6: When an input value c is held for at least 8·NSEC + latency − 1 clocks, `y_out` settles to 2·c·Σh in add mode and to 0 in subtract mode, and stays constant while c is held.
- R7: Each folded pair word is DW+1 bits wide, so full-scale inputs never wrap inside the pre-combiner. A constant −2^(DW−1) gives the exact R6 value, and full-scale alternating inputs match R1.
- R8: With NSEC sections, section s uses taps 8s to 8s+7 of one shared delay line and coefficients COEFS[4s] to COEFS[4s+3]. `y_out` is the sum of all section results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample is taken on every rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| x_in | input | DW | Two's complement input sample |
| y_out | output | OW | Two's complement filter output (default width DW+NSEC+CW) |

## Verification
A damaged delay-line word or a wrong folded word shows up as a wrong `y_out` exactly one latency after the faulty sample enters. It stays visible for up to eight clocks per section, until that sample leaves the window, so an impulse exposes a bad tap at a single, predictable output position. A wrong table entry or a wrongly weighted sign plane corrupts every output whose bits select it. It shows in the impulse and DC values within three clocks. An incomplete clear leaves old samples in the window, and they appear as non-zero outputs within eight clocks per section after a fresh impulse.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

    // How the two members of a mirrored tap pair are combined
    typedef enum logic {
        FOLD_ADD = 1'b0,
        FOLD_SUB = 1'b1
    } fold_e;

endpackage

// File: rtl/fir_fold.sv
// Combines the eight taps of one section into four mirrored pair words.
module fir_fold
    import fir_da_pkg::*;
#(
    parameter int    DW   = 8,
    parameter fold_e FOLD = FOLD_ADD,
    localparam int   PW   = DW + 1
) (
    input  logic [7:0][DW-1:0] tap,
    output logic [3:0][PW-1:0] pair
);

    logic [3:0][PW-1:0] near_w;
    logic [3:0][PW-1:0] far_w;

    for (genvar k = 0; k < 4; k++) begin : g_ext
        assign near_w[k] = {tap[k][DW-1], tap[k]};
        assign far_w[k]  = {tap[7-k][DW-1], tap[7-k]};
    end

    if (FOLD == FOLD_ADD) begin : g_add
        for (genvar k = 0; k < 4; k++) begin : g_k
            assign pair[k] = near_w[k] + far_w[k];
        end
    end else begin : g_sub
        for (genvar k = 0; k < 4; k++) begin : g_k
            assign pair[k] = near_w[k] - far_w[k];
        end
    end

endmodule

// File: rtl/fir_da_vmul.sv
// Four-input constant vector multiplier built from subset-sum tables.
module fir_da_vmul #(
    parameter int PW = 9,
    parameter int CW = 8,
    parameter int IW = 17,
    parameter logic [3:0][CW-1:0] COEF = '0
) (
    input  logic [3:0][PW-1:0] word,
    output logic [IW-1:0]      prod
);

    function automatic logic [IW-1:0] subset_sum(input int sel);
        logic [IW-1:0] acc;
        acc = '0;
        for (int i = 0; i < 4; i++) begin
            if (sel[i]) acc = acc + IW'($signed(COEF[i]));
        end
        return acc;
    endfunction

    logic [IW-1:0] lut [16];

    for (genvar a = 0; a < 16; a++) begin : g_lut
        assign lut[a] = subset_sum(a);
    end

    always_comb begin
        logic [3:0]    addr;
        logic [IW-1:0] term;
        prod = '0;
        for (int b = 0; b < PW; b++) begin
            addr = {word[3][b], word[2][b], word[1][b], word[0][b]};
            term = lut[addr] << b;
            if (b == PW - 1) prod = prod - term;
            else             prod = prod + term;
        end
    end

endmodule

// File: rtl/sym_da_fir.sv
module sym_da_fir
    import fir_da_pkg::*;
#(
    parameter int    DW   = 8,
    parameter int    CW   = 8,
    parameter int    NSEC = 1,
    parameter int    OW   = DW + NSEC + CW,
    parameter int    IW   = OW,
    parameter bit    PIPE = 1'b1,
    parameter fold_e FOLD = FOLD_ADD,
    parameter logic [NSEC*4-1:0][CW-1:0] COEFS = {8'sd100, 8'sd45, -8'sd10, -8'sd3}
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [DW-1:0] x_in,
    output logic [OW-1:0] y_out
);

    localparam int NTAP  = 8 * NSEC;
    localparam int NPAIR = 4 * NSEC;
    localparam int PW    = DW + 1;

    typedef struct packed {
        logic [NTAP-1:0][DW-1:0]  taps;
        logic [NPAIR-1:0][PW-1:0] pre;
        logic [OW-1:0]            y;
    } state_t;

    state_t st_d, st_q;

    logic [NPAIR-1:0][PW-1:0] fold_w;
    logic [IW-1:0]            sec_prod [NSEC];
    logic [IW-1:0]            acc_w;
    logic [OW-1:0]            y_scaled;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        logic [3:0][PW-1:0] pw;
        logic [3:0][PW-1:0] mac_in;
        logic [IW-1:0]      part;

        fir_fold #(.DW(DW), .FOLD(FOLD)) u_fold (
            .tap  (st_q.taps[8*s +: 8]),
            .pair (pw)
        );

        assign fold_w[4*s +: 4] = pw;

        if (PIPE) begin : g_reg
            assign mac_in = st_q.pre[4*s +: 4];
        end else begin : g_comb
            assign mac_in = pw;
        end

        fir_da_vmul #(
            .PW(PW), .CW(CW), .IW(IW), .COEF(COEFS[4*s +: 4])
        ) u_vmul (
            .word (mac_in),
            .prod (part)
        );

        assign sec_prod[s] = part;
    end

    always_comb begin
        acc_w = '0;
        for (int s = 0; s < NSEC; s++) acc_w = acc_w + sec_prod[s];
    end

    if (OW <= IW) begin : g_trim
        assign y_scaled = acc_w[IW-1 -: OW];
    end else begin : g_ext
        assign y_scaled = {{(OW-IW){acc_w[IW-1]}}, acc_w};
    end

    always_comb begin
        st_d      = st_q;
        st_d.taps = {st_q.taps[NTAP-2:0], x_in};
        st_d.pre  = fold_w;
        st_d.y    = y_scaled;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    assign y_out = st_q.y;

endmodule

// File: rtl/fir_da_chk.sv
module fir_da_chk
    import fir_da_pkg::*;
#(
    parameter int    DW   = 8,
    parameter int    CW   = 8,
    parameter int    NSEC = 1,
    parameter int    OW   = DW + NSEC + CW,
    parameter int    IW   = OW,
    parameter bit    PIPE = 1'b1,
    parameter fold_e FOLD = FOLD_ADD,
    parameter logic [NSEC*4-1:0][CW-1:0] COEFS = '0
) (
    input logic          clk,
    input logic          clr,
    input logic [DW-1:0] x_in,
    input logic [OW-1:0] y_out
);

    localparam int LAT    = PIPE ? 3 : 2;
    localparam int SETTLE = 8 * NSEC + LAT - 1;
    localparam int RW     = $clog2(SETTLE + 2) + 1;

    function automatic logic [OW-1:0] dc_val(input logic [DW-1:0] c);
        longint        sumh;
        longint        v;
        longint        w;
        logic [IW-1:0] vi;
        sumh = 0;
        for (int i = 0; i < NSEC * 4; i++) sumh = sumh + longint'($signed(COEFS[i]));
        v  = (FOLD == FOLD_ADD) ? 2 * longint'($signed(c)) * sumh : 0;
        vi = v[IW-1:0];
        w  = longint'($signed(vi));
        if (OW < IW) w = w >>> (IW - OW);
        return w[OW-1:0];
    endfunction

    logic [3:0]    since_q;
    logic [RW-1:0] run_q;
    logic [DW-1:0] last_q;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            since_q <= '0;
            run_q   <= '0;
            last_q  <= '0;
        end else begin
            if (int'(since_q) < LAT) since_q <= since_q + 4'd1;
            last_q <= x_in;
            if (x_in != last_q)              run_q <= RW'(1);
            else if (int'(run_q) <= SETTLE)  run_q <= run_q + RW'(1);
        end
    end

    // R5: output held at zero during clear
    p_clear_zero_r5: assert property (@(posedge clk) clr |-> y_out == '0);

    // R5: no residue before the first new sample can arrive
    p_start_zero_r5: assert property (@(posedge clk) disable iff (clr)
        (int'(since_q) < LAT) |-> y_out == '0);

    // R6: settled DC value
    p_dc_value_r6: assert property (@(posedge clk) disable iff (clr)
        (int'(run_q) >= SETTLE) |-> y_out == dc_val(last_q));

    // R6: output steady while input is held
    p_dc_steady_r6: assert property (@(posedge clk) disable iff (clr)
        (int'(run_q) > SETTLE) |-> $stable(y_out));

endmodule

bind sym_da_fir fir_da_chk #(
    .DW(DW), .CW(CW), .NSEC(NSEC), .OW(OW), .IW(IW),
    .PIPE(PIPE), .FOLD(FOLD), .COEFS(COEFS)
) u_chk (
    .clk   (clk),
    .clr   (clr),
    .x_in  (x_in),
    .y_out (y_out)
);

// File: tb/tb_sym_da_fir.sv
module tb_sym_da_fir;
    import fir_da_pkg::*;

    localparam int CLK_NS = 10;
    localparam logic [3:0][7:0] CF1 = {8'sd100, 8'sd45, -8'sd10, -8'sd3};
    localparam logic [7:0][7:0] CF2 = {8'sd1, 8'sd3, -8'sd7, 8'sd20,
                                       8'sd100, 8'sd45, -8'sd10, -8'sd3};

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [7:0]  x_in = '0;
    logic [16:0] y_sym;
    logic [16:0] y_anti;
    logic [17:0] y_casc;

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 1'b0;
    int  hist [32];

    always #(CLK_NS/2) clk = ~clk;

    sym_da_fir dut (.clk(clk), .clr(clr), .x_in(x_in), .y_out(y_sym));

    sym_da_fir #(.PIPE(1'b0), .FOLD(FOLD_SUB)) dut_anti (
        .clk(clk), .clr(clr), .x_in(x_in), .y_out(y_anti));

    sym_da_fir #(.NSEC(2), .COEFS(CF2)) dut_casc (
        .clk(clk), .clr(clr), .x_in(x_in), .y_out(y_casc));

    function automatic longint ref_out(input int nsec, input bit anti,
                                       input logic [7:0][7:0] cf,
                                       input int lat, input int ow);
        longint acc;
        longint p;
        acc = 0;
        for (int s = 0; s < nsec; s++) begin
            for (int k = 0; k < 4; k++) begin
                p = anti ? longint'(hist[lat-1+8*s+k]) - longint'(hist[lat-1+8*s+7-k])
                         : longint'(hist[lat-1+8*s+k]) + longint'(hist[lat-1+8*s+7-k]);
                acc = acc + longint'($signed(cf[4*s+k])) * p;
            end
        end
        acc = (acc <<< (64 - ow)) >>> (64 - ow);
        return acc;
    endfunction

    task automatic check(input string req, input string who,
                         input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, who, act, exp);
        end
    endtask

    task automatic check_all(input string rs, input string ra, input string rc);
        check(rs, "sym",  longint'($signed(y_sym)),  ref_out(1, 1'b0, {32'h0, CF1}, 3, 17));
        check(ra, "anti", longint'($signed(y_anti)), ref_out(1, 1'b1, {32'h0, CF1}, 2, 17));
        check(rc, "casc", longint'($signed(y_casc)), ref_out(2, 1'b0, CF2, 3, 18));
    endtask

    task automatic step(input logic [7:0] x, input string rs,
                        input string ra, input string rc);
        @(negedge clk);
        x_in = x;
        @(posedge clk);
        for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = int'($signed(x));
        #(CLK_NS/4);
        check_all(rs, ra, rc);
    endtask

    task automatic do_clear(input string req);
        @(negedge clk);
        clr  = 1'b1;
        x_in = 8'h55;
        for (int i = 0; i < 32; i++) hist[i] = 0;
        #1;
        check(req, "sym clear",  longint'(y_sym),  0);
        check(req, "anti clear", longint'(y_anti), 0);
        check(req, "casc clear", longint'(y_casc), 0);
        @(posedge clk);
        #(CLK_NS/4);
        check(req, "sym held", longint'(y_sym), 0);
        @(negedge clk);
        clr  = 1'b0;
        x_in = '0;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #(CLK_NS/4);
        check("R5", "sym reset",  longint'(y_sym),  0);
        check("R5", "anti reset", longint'(y_anti), 0);
        check("R5", "casc reset", longint'(y_casc), 0);
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_impulse;
        step(8'd1, "R2", "R3", "R8");
        for (int i = 0; i < 20; i++) step(8'd0, "R2", "R3", "R8");
        step(8'hFF, "R2", "R3", "R8");
        for (int i = 0; i < 20; i++) step(8'd0, "R2", "R3", "R8");
    endtask

    task automatic t_random;
        for (int i = 0; i < 60; i++) step(8'($urandom_range(0, 255)), "R1", "R4", "R8");
    endtask

    task automatic t_dc;
        for (int i = 0; i < 24; i++) step(8'd37, "R6", "R6", "R6");
        check("R6", "sym dc",  longint'($signed(y_sym)),  9768);
        check("R6", "anti dc", longint'($signed(y_anti)), 0);
        check("R6", "casc dc", longint'($signed(y_casc)), 11026);
    endtask

    task automatic t_fullscale;
        for (int i = 0; i < 24; i++) step(8'h80, "R7", "R7", "R7");
        check("R7", "sym min",  longint'($signed(y_sym)),  -33792);
        check("R7", "anti min", longint'($signed(y_anti)), 0);
        check("R7", "casc min", longint'($signed(y_casc)), -38144);
        for (int i = 0; i < 20; i++) step((i % 2 == 0) ? 8'h7F : 8'h80, "R7", "R7", "R7");
    endtask

    task automatic t_midclear;
        for (int i = 0; i < 10; i++) step(8'($urandom_range(0, 255)), "R1", "R4", "R8");
        do_clear("R5");
        step(8'd5, "R5", "R5", "R5");
        for (int i = 0; i < 20; i++) step(8'd0, "R5", "R5", "R5");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) hist[i] = 0;
        t_reset();
        t_impulse();
        t_random();
        t_dc();
        t_fullscale();
        t_midclear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule